// File: doc/BRIEF.md
# Thread Interrupt Priority Context

This block keeps the interrupt management state of a single hardware thread. The state is a 64-byte context file split into four 16-byte rings: user, OS, pool and physical. A presenter delivers notifications tagged with a ring and a priority. Each one sets a bit in that ring's pending-priority bitmap. Every ring compares its most favoured pending priority against its own current-priority register. The OS ring drives the OS interrupt line. The pool and physical rings together drive the hypervisor interrupt line.

Software reaches the context through a window of four pages. Page 0 is the hardware view and page 1 is the hypervisor view. Both can reach every ring. Page 2 is the OS view and reaches only the user and OS rings. Page 3 is the user view and reaches only the user ring. Reading a ring's acknowledge byte returns the winning priority, retires it from the bitmap and raises the ring's current priority to that level.

Priorities 0 to 7 are active, and 0 is the most favoured. The value 0xFF stands for the least favoured level. It is returned when nothing is pending.

Top module: `thread_irq_ctx`

## Requirements
- R1: Access address bits [5:4] select the ring (0 user, 1 OS, 2 pool, 3 physical) and bits [3:0] select the byte. Within a ring, byte 0 is the pending bitmap, byte 1 is the current priority and byte 2 is the acknowledge byte. Bytes 3 to 15 are plain storage that can be read and written.
- R2: The data of a read appears on acc_rdata_o in the cycle after the access. In a cycle that follows no granted read, acc_rdata_o is 0x00.
- R3: A notification at priority p with p at most 7 sets bit (7 - p) of the target ring's pending bitmap, so priority 0 sets 0x80. A notification above 7 changes nothing.
- R4: os_irq_o is high exactly when the OS ring's most favoured pending priority is numerically below that ring's current priority. hv_irq_o is high exactly when the same holds for the pool ring or for the physical ring. An empty bitmap counts as 0xFF.
- R5: A read of the acknowledge byte returns the most favoured pending priority, or 0xFF if the bitmap is empty. The same read clears that priority's bit and loads the value into the current-priority byte.
- R6: Pages 0 and 1 reach all rings. Page 2 reaches rings 0 and 1 only. Page 3 reaches ring 0 only. A read outside a page's reach returns 0x00, and a write outside it changes nothing.
- R7: A write to the acknowledge byte changes nothing. A notification that arrives in the same cycle as a write or an acknowledge to its ring is never lost.
- R8: After reset every context byte, including every pending bitmap and every current priority, is 0x00, and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ntf_valid_i | input | 1 | Notification strobe |
| ntf_ring_i | input | 2 | Ring targeted by the notification |
| ntf_prio_i | input | 8 | Priority of the notification |
| acc_valid_i | input | 1 | Context access strobe |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_page_i | input | 2 | Privilege page of the access |
| acc_addr_i | input | 6 | Byte address in the context file |
| acc_wdata_i | input | 8 | Write data |
| acc_rdata_o | output | 8 | Registered read data |
| os_irq_o | output | 1 | OS-level interrupt |
| hv_irq_o | output | 1 | Hypervisor-level interrupt |

## Verification
The assertions check several properties on every cycle. A notification above priority 7 never moves the interrupt lines. A read beyond a page's reach always returns zero. An acknowledge only ever yields a legal priority or 0xFF. The OS line only rises after a notification or a write.

The exact arbitration needs the bench's scenarios. This covers which bit an acknowledge retires, how pending bits combine across several notifications, and a notification colliding with an acknowledge on the same ring. A behavioural model of the 64-byte file checks all of these on every clock, alongside directed cases for each page boundary.

// File: rtl/tctx_pkg.sv
package tctx_pkg;
  localparam int PRIO_W  = 8;
  localparam int N_LVL   = 8;
  localparam int RING_B  = 16;
  localparam int N_RING  = 4;
  localparam int N_PAGE  = 4;
  localparam int OFF_W   = $clog2(RING_B);
  localparam int RING_W  = $clog2(N_RING);
  localparam int ADDR_W  = OFF_W + RING_W;
  localparam int PAGE_W  = $clog2(N_PAGE);

  localparam logic [OFF_W-1:0] OFF_PND = 'd0;
  localparam logic [OFF_W-1:0] OFF_CPR = 'd1;
  localparam logic [OFF_W-1:0] OFF_ACK = 'd2;
  localparam int               GP_BASE = 3;

  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  localparam int RING_USER = 0;
  localparam int RING_OS   = 1;
  localparam int RING_POOL = 2;
  localparam int RING_PHYS = 3;

  // privilege pages: a page at or below PAGE_HV sees every ring
  localparam int PAGE_HV = 1;
endpackage

// File: rtl/tctx_prio_enc.sv
module tctx_prio_enc #(
  parameter int N_LVL  = tctx_pkg::N_LVL,
  parameter int PRIO_W = tctx_pkg::PRIO_W
) (
  input  logic [N_LVL-1:0]  pnd_i,
  output logic [PRIO_W-1:0] best_o,
  output logic [N_LVL-1:0]  best_bit_o
);
  // bit (N_LVL-1-p) carries priority p; the highest set bit wins
  always_comb begin
    best_o     = '1;
    best_bit_o = '0;
    for (int i = 0; i < N_LVL; i++) begin
      if (pnd_i[i]) begin
        best_o     = PRIO_W'(N_LVL - 1 - i);
        best_bit_o = N_LVL'(1) << i;
      end
    end
  end
endmodule

// File: rtl/tctx_page_gate.sv
module tctx_page_gate #(
  parameter int N_PAGE = tctx_pkg::N_PAGE,
  parameter int N_RING = tctx_pkg::N_RING
) (
  input  logic [$clog2(N_PAGE)-1:0] page_i,
  input  logic [$clog2(N_RING)-1:0] ring_i,
  output logic                      allow_o
);
  localparam int PAGE_W = $clog2(N_PAGE);

  // less privileged pages reach ring indices up to (N_PAGE-1-page)
  logic [PAGE_W-1:0] reach;
  assign reach   = PAGE_W'(N_PAGE - 1) - page_i;
  assign allow_o = (int'(page_i) <= tctx_pkg::PAGE_HV) || (int'(ring_i) <= int'(reach));
endmodule

// File: rtl/tctx_ring.sv
module tctx_ring #(
  parameter int N_LVL  = tctx_pkg::N_LVL,
  parameter int PRIO_W = tctx_pkg::PRIO_W,
  parameter int RING_B = tctx_pkg::RING_B
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_LVL-1:0]          ntf_set_i,
  input  logic                      sel_i,
  input  logic                      we_i,
  input  logic [$clog2(RING_B)-1:0] off_i,
  input  logic [PRIO_W-1:0]         wdata_i,
  output logic [PRIO_W-1:0]         rdata_o,
  output logic                      irq_o
);
  import tctx_pkg::*;
  localparam int OW   = $clog2(RING_B);
  localparam int GP_N = RING_B - GP_BASE;

  logic [N_LVL-1:0]  pnd_q, pnd_d;
  logic [PRIO_W-1:0] cpr_q, cpr_d;
  logic [PRIO_W-1:0] gp_q [GP_N];
  logic [PRIO_W-1:0] best;
  logic [N_LVL-1:0]  best_bit;
  logic              ack, wr_pnd, wr_cpr, wr_gp;
  logic [OW-1:0]     gp_idx;

  tctx_prio_enc #(.N_LVL(N_LVL), .PRIO_W(PRIO_W)) u_enc (
    .pnd_i      (pnd_q),
    .best_o     (best),
    .best_bit_o (best_bit)
  );

  assign ack    = sel_i && !we_i && (off_i == OFF_ACK);
  assign wr_pnd = sel_i && we_i && (off_i == OFF_PND);
  assign wr_cpr = sel_i && we_i && (off_i == OFF_CPR);
  assign wr_gp  = sel_i && we_i && (int'(off_i) >= GP_BASE);
  assign gp_idx = off_i - OW'(GP_BASE);

  // a notification is merged last so it survives a same-cycle write or ack
  always_comb begin
    pnd_d = wr_pnd ? wdata_i[N_LVL-1:0] : pnd_q;
    if (ack) pnd_d = pnd_d & ~best_bit;
    pnd_d = pnd_d | ntf_set_i;
  end

  always_comb begin
    cpr_d = cpr_q;
    if (wr_cpr)   cpr_d = wdata_i;
    else if (ack) cpr_d = best;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pnd_q <= '0;
      cpr_q <= '0;
    end else begin
      pnd_q <= pnd_d;
      cpr_q <= cpr_d;
    end
  end

  generate
    for (genvar g = 0; g < GP_N; g++) begin : g_gp
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           gp_q[g] <= '0;
        else if (wr_gp && gp_idx == OW'(g))    gp_q[g] <= wdata_i;
      end
    end
  endgenerate

  always_comb begin
    case (off_i)
      OFF_PND: rdata_o = PRIO_W'(pnd_q);
      OFF_CPR: rdata_o = cpr_q;
      OFF_ACK: rdata_o = best;
      default: rdata_o = gp_q[gp_idx];
    endcase
  end

  assign irq_o = best < cpr_q;
endmodule

// File: rtl/thread_irq_ctx.sv
module thread_irq_ctx #(
  parameter int N_LVL  = tctx_pkg::N_LVL,
  parameter int PRIO_W = tctx_pkg::PRIO_W,
  parameter int RING_B = tctx_pkg::RING_B,
  parameter int N_RING = tctx_pkg::N_RING,
  parameter int N_PAGE = tctx_pkg::N_PAGE,
  localparam int OFF_W  = $clog2(RING_B),
  localparam int RING_W = $clog2(N_RING),
  localparam int ADDR_W = OFF_W + RING_W,
  localparam int PAGE_W = $clog2(N_PAGE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ntf_valid_i,
  input  logic [RING_W-1:0] ntf_ring_i,
  input  logic [PRIO_W-1:0] ntf_prio_i,
  input  logic              acc_valid_i,
  input  logic              acc_we_i,
  input  logic [PAGE_W-1:0] acc_page_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [PRIO_W-1:0] acc_wdata_i,
  output logic [PRIO_W-1:0] acc_rdata_o,
  output logic              os_irq_o,
  output logic              hv_irq_o
);
  import tctx_pkg::*;

  logic [RING_W-1:0] ring;
  logic [OFF_W-1:0]  off;
  logic              allow, ntf_ok;
  logic [N_LVL-1:0]  ntf_bit;
  logic [PRIO_W-1:0] ring_rdata [N_RING];
  logic [N_RING-1:0] ring_irq;
  logic [PRIO_W-1:0] rdata_q;

  assign ring = acc_addr_i[ADDR_W-1:OFF_W];
  assign off  = acc_addr_i[OFF_W-1:0];

  tctx_page_gate #(.N_PAGE(N_PAGE), .N_RING(N_RING)) u_gate (
    .page_i  (acc_page_i),
    .ring_i  (ring),
    .allow_o (allow)
  );

  assign ntf_ok  = ntf_valid_i && (ntf_prio_i < PRIO_W'(N_LVL));
  assign ntf_bit = ntf_ok ? (N_LVL'(1) << (N_LVL - 1 - int'(ntf_prio_i[$clog2(N_LVL)-1:0])))
                          : '0;

  generate
    for (genvar r = 0; r < N_RING; r++) begin : g_ring
      tctx_ring #(.N_LVL(N_LVL), .PRIO_W(PRIO_W), .RING_B(RING_B)) u_ring (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ntf_set_i ((ntf_ring_i == RING_W'(r)) ? ntf_bit : '0),
        .sel_i     (acc_valid_i && allow && ring == RING_W'(r)),
        .we_i      (acc_we_i),
        .off_i     (off),
        .wdata_i   (acc_wdata_i),
        .rdata_o   (ring_rdata[r]),
        .irq_o     (ring_irq[r])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  rdata_q <= '0;
    else if (acc_valid_i && !acc_we_i && allow)   rdata_q <= ring_rdata[ring];
    else                                          rdata_q <= '0;
  end

  assign acc_rdata_o = rdata_q;
  assign os_irq_o    = ring_irq[RING_OS];
  assign hv_irq_o    = ring_irq[RING_POOL] | ring_irq[RING_PHYS];
endmodule

// File: rtl/tctx_chk.sv
module tctx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ntf_valid_i,
  input logic [1:0] ntf_ring_i,
  input logic [7:0] ntf_prio_i,
  input logic       acc_valid_i,
  input logic       acc_we_i,
  input logic [1:0] acc_page_i,
  input logic [5:0] acc_addr_i,
  input logic [7:0] acc_wdata_i,
  input logic [7:0] acc_rdata_o,
  input logic       os_irq_o,
  input logic       hv_irq_o
);
  logic quiet_hi_ntf;
  assign quiet_hi_ntf = ntf_valid_i && ntf_prio_i > 8'd7 && !acc_valid_i;

  AST_HI_PRIO_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet_hi_ntf |=> $stable(os_irq_o) && $stable(hv_irq_o)); // R3

  AST_USER_PAGE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_we_i && acc_page_i == 2'd3 && acc_addr_i[5:4] != 2'd0)
      |=> acc_rdata_o == 8'h00); // R6

  AST_OS_PAGE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_we_i && acc_page_i == 2'd2 && acc_addr_i[5] == 1'b1)
      |=> acc_rdata_o == 8'h00); // R6

  AST_ACK_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_we_i && acc_page_i == 2'd0 && acc_addr_i[3:0] == 4'd2)
      |=> (acc_rdata_o <= 8'd7 || acc_rdata_o == 8'hFF)); // R5

  AST_OS_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(os_irq_o) |-> $past(ntf_valid_i || (acc_valid_i && acc_we_i))); // R4

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> acc_rdata_o == 8'h00); // R2
endmodule

bind thread_irq_ctx tctx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ntf_valid_i (ntf_valid_i),
  .ntf_ring_i  (ntf_ring_i),
  .ntf_prio_i  (ntf_prio_i),
  .acc_valid_i (acc_valid_i),
  .acc_we_i    (acc_we_i),
  .acc_page_i  (acc_page_i),
  .acc_addr_i  (acc_addr_i),
  .acc_wdata_i (acc_wdata_i),
  .acc_rdata_o (acc_rdata_o),
  .os_irq_o    (os_irq_o),
  .hv_irq_o    (hv_irq_o)
);

// File: tb/tb_thread_irq_ctx.sv
module tb_thread_irq_ctx;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ntf_valid_i = 1'b0;
  logic [1:0] ntf_ring_i = '0;
  logic [7:0] ntf_prio_i = '0;
  logic       acc_valid_i = 1'b0;
  logic       acc_we_i = 1'b0;
  logic [1:0] acc_page_i = '0;
  logic [5:0] acc_addr_i = '0;
  logic [7:0] acc_wdata_i = '0;
  logic [7:0] acc_rdata_o;
  logic       os_irq_o, hv_irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  thread_irq_ctx dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // behavioural reference: flat byte array of the whole context
  byte unsigned m [64];
  byte unsigned exp_rd;
  bit exp_os, exp_hv;

  function automatic int best_of(byte unsigned pb);
    for (int p = 0; p < 8; p++) if (pb[7-p]) return p;
    return 255;
  endfunction

  function automatic bit reach(int page, int ring);
    if (page <= 1) return 1;
    if (page == 2) return ring <= 1;
    return ring == 0;
  endfunction

  function automatic bit ring_irq(int r);
    return best_of(m[r*16]) < int'(m[r*16+1]);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (m[i]) m[i] = 0;
      exp_rd = 0;
    end else begin
      int r, o, b;
      byte unsigned nb;
      exp_rd = 0;
      r = int'(acc_addr_i[5:4]);
      o = int'(acc_addr_i[3:0]);
      nb = 0;
      if (ntf_valid_i && ntf_prio_i <= 7) nb = byte'(8'h80 >> ntf_prio_i);
      if (acc_valid_i && reach(int'(acc_page_i), r)) begin
        if (acc_we_i) begin
          if (o != 2) m[int'(acc_addr_i)] = acc_wdata_i;
        end else if (o == 2) begin
          b = best_of(m[r*16]);
          exp_rd = byte'(b);
          if (b < 8) m[r*16] = m[r*16] & ~byte'(8'h80 >> b);
          m[r*16+1] = byte'(b);
        end else begin
          exp_rd = m[int'(acc_addr_i)];
        end
      end
      m[int'(ntf_ring_i)*16] = m[int'(ntf_ring_i)*16] | nb;
    end
    exp_os = ring_irq(1);
    exp_hv = ring_irq(2) | ring_irq(3);
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R2 rdata", acc_rdata_o, exp_rd);
      chk("R4 os_irq", {7'd0, os_irq_o}, {7'd0, exp_os});
      chk("R4 hv_irq", {7'd0, hv_irq_o}, {7'd0, exp_hv});
    end
  end

  task automatic rd(int page, int addr, logic [7:0] exp, string tag);
    @(negedge clk_i);
    acc_valid_i = 1; acc_we_i = 0; acc_page_i = 2'(page); acc_addr_i = 6'(addr);
    @(negedge clk_i);
    acc_valid_i = 0;
    chk(tag, acc_rdata_o, exp);
  endtask

  task automatic wr(int page, int addr, logic [7:0] d);
    @(negedge clk_i);
    acc_valid_i = 1; acc_we_i = 1; acc_page_i = 2'(page); acc_addr_i = 6'(addr);
    acc_wdata_i = d;
    @(negedge clk_i);
    acc_valid_i = 0; acc_we_i = 0;
  endtask

  task automatic ntf(int ring, int prio);
    @(negedge clk_i);
    ntf_valid_i = 1; ntf_ring_i = 2'(ring); ntf_prio_i = 8'(prio);
    @(negedge clk_i);
    ntf_valid_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R8 reset state
    chk("R8 os_irq", {7'd0, os_irq_o}, 8'd0);
    chk("R8 hv_irq", {7'd0, hv_irq_o}, 8'd0);
    rd(0, 6'h10, 8'h00, "R8 os pending");
    rd(0, 6'h31, 8'h00, "R8 phys cppr");
    // R3/R4 notification and arbitration on the OS ring
    wr(2, 6'h11, 8'hFF);
    ntf(1, 5);
    chk("R4 os raised", {7'd0, os_irq_o}, 8'd1);
    ntf(1, 9);
    rd(2, 6'h10, 8'h04, "R3 prio above 7 ignored");
    ntf(1, 0);
    rd(2, 6'h10, 8'h84, "R3 prio 0 bit");
    // R5 acknowledge
    rd(2, 6'h12, 8'h00, "R5 ack value");
    rd(2, 6'h10, 8'h04, "R5 ack clears bit");
    rd(2, 6'h11, 8'h00, "R5 ack sets cppr");
    chk("R4 os masked", {7'd0, os_irq_o}, 8'd0);
    rd(0, 6'h02, 8'hFF, "R5 empty ack");
    rd(0, 6'h01, 8'hFF, "R5 empty ack cppr");
    // R6 page gating, R1 storage bytes
    wr(3, 6'h11, 8'h77);
    rd(0, 6'h11, 8'h00, "R6 user write to os ring ignored");
    rd(3, 6'h11, 8'h00, "R6 user read of os ring");
    wr(0, 6'h35, 8'hA5);
    rd(1, 6'h35, 8'hA5, "R1 storage byte");
    rd(2, 6'h35, 8'h00, "R6 os read of phys ring");
    wr(2, 6'h2F, 8'h3C);
    rd(0, 6'h2F, 8'h00, "R6 os write to pool ring ignored");
    // R4 hypervisor line
    wr(1, 6'h31, 8'h03);
    ntf(3, 2);
    chk("R4 hv raised", {7'd0, hv_irq_o}, 8'd1);
    // R7 write to ack ignored, collision kept
    wr(0, 6'h32, 8'h55);
    rd(0, 6'h30, 8'h20, "R7 ack write ignored");
    @(negedge clk_i);
    ntf_valid_i = 1; ntf_ring_i = 2'd3; ntf_prio_i = 8'd2;
    acc_valid_i = 1; acc_we_i = 0; acc_page_i = 2'd0; acc_addr_i = 6'h32;
    @(negedge clk_i);
    ntf_valid_i = 0; acc_valid_i = 0;
    chk("R7 ack during notify", acc_rdata_o, 8'h02);
    rd(0, 6'h30, 8'h20, "R7 notify survives ack");
    @(negedge clk_i);
    chk("R2 idle rdata", acc_rdata_o, 8'h00);
    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk_i);
      ntf_valid_i = ($urandom_range(0, 2) == 0);
      ntf_ring_i  = 2'($urandom_range(0, 3));
      ntf_prio_i  = 8'($urandom_range(0, 10));
      acc_valid_i = ($urandom_range(0, 1) == 1);
      acc_we_i    = ($urandom_range(0, 2) == 0);
      acc_page_i  = 2'($urandom_range(0, 3));
      acc_addr_i  = {2'($urandom_range(0, 3)), 4'($urandom_range(0, 4) == 0 ? $urandom_range(3, 15) : $urandom_range(0, 2))};
      acc_wdata_i = ($urandom_range(0, 1) == 1) ? 8'hFF : 8'($urandom_range(0, 255));
    end
    @(negedge clk_i);
    ntf_valid_i = 0; acc_valid_i = 0;
    @(negedge clk_i);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule